// File: doc/BRIEF.md
# Key-Armed Watchdog with Reset Stretcher

This block is a watchdog for a small controller core. It counts machine cycles, marked by a one-clock enable, and requests a system reset if software stops servicing it. The counter starts out off. Software turns it on, and later keeps it alive, by writing a two-byte key to a service register that can only be written. Nothing can read the count, preset it, or switch it off again. Only the block's own reset, or a hardware reset, returns it to the off state.

When the count expires, the block raises an internal reset request for a fixed number of oscillator clocks. The same request clears the watchdog back to its off state. A separate pin-drive output copies the request onto the board reset pin, unless a configuration input keeps that pin as an input only. Two other inputs control counting in low-power states. One selects whether counting freezes while the core idles. In power-down the count always stops. After a wake-up caused by an interrupt, counting stays held until the interrupt line has gone high again.

Top module: `wdog_unlock`

## Requirements
- R1: After reset, with no complete key written, `wdt_reset_req` and `rst_pin_drive` stay 0.
- R2: A write of 0x1E followed by a write of 0xE1 on the next service write turns the watchdog on with a zero count. The first reset request then starts exactly 16383 (0x3FFF) counted machine cycles later.
- R3: Writing the complete key again while the watchdog is on sets the count back to zero, so the request comes 16383 counted machine cycles after the second key.
- R4: After 0x1E, any service write other than 0xE1 cancels the key. A 0xE1 without a 0x1E directly before it has no effect. A repeated 0x1E starts the key afresh.
- R5: The count advances only on clocks where `cyc_en` is 1.
- R6: `wdt_reset_req` stays high for exactly 98 consecutive clocks.
- R7: With `rstout_dis` = 1, `rst_pin_drive` stays 0 through the whole request. With `rstout_dis` = 0, it is high on every clock of the request.
- R8: While `idle` = 1, the count keeps advancing if `halt_in_idle` = 0 and holds if `halt_in_idle` = 1. Counting resumes when idle ends.
- R9: The count holds while `pdown` = 1. After a `pd_wake` pulse, it holds from the next clock until the clock after `irq_n` is seen high.
- R10: After a request ends, the watchdog is off and issues no further request until a new complete key is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Hardware reset, active low |
| cyc_en | input | 1 | Machine-cycle enable, one clock wide |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 8 | Byte written to the service register |
| idle | input | 1 | Core is in idle |
| halt_in_idle | input | 1 | 1: freeze the count during idle |
| pdown | input | 1 | Core is in power-down |
| pd_wake | input | 1 | Pulse: power-down ended by an external interrupt |
| irq_n | input | 1 | Level of the interrupt line that woke the core |
| rstout_dis | input | 1 | 1: never drive the reset pin |
| wdt_reset_req | output | 1 | Internal reset request, 98 clocks long |
| rst_pin_drive | output | 1 | Drive-high enable for the reset pin |

## Verification
Every run arms the counter and measures the clock or machine-cycle distance to the first request. The bench computes the expected distance from 0x3FFF plus the number of frozen clocks its own stimulus creates. A continuous enable run and a run with one enable in four missing show the difference between counting clocks and counting machine cycles. In a single gating run, idle is applied with and without the halt option, then power-down, then an interrupt hold. Only frozen clocks add to the distance, so an error in any one gate moves the result. Runs with broken keys, a restart key, and a long quiet window after reset and after a request show whether a key is accepted, restarted or rejected.

// File: rtl/wdog_unlock.sv
module wdog_unlock #(
  parameter int          CNT_W      = 14,
  parameter int          PULSE_LEN  = 98,
  parameter logic [7:0]  KEY_FIRST  = 8'h1E,
  parameter logic [7:0]  KEY_SECOND = 8'hE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       idle,
  input  logic       halt_in_idle,
  input  logic       pdown,
  input  logic       pd_wake,
  input  logic       irq_n,
  input  logic       rstout_dis,
  output logic       wdt_reset_req,
  output logic       rst_pin_drive
);

  localparam int                PW    = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0]  CLAST = {CNT_W{1'b1}} - 1'b1;

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pls;
  logic             armed, key_half, wake_hold;

  wire in_rst   = (pls != '0);
  wire key_done = wr_en && key_half && (wr_data == KEY_SECOND) && !in_rst;
  wire advance  = armed && cyc_en && !pdown && !wake_hold &&
                  !(idle && halt_in_idle) && !in_rst;
  wire hit      = advance && (cnt == CLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      pls       <= '0;
      armed     <= 1'b0;
      key_half  <= 1'b0;
      wake_hold <= 1'b0;
    end else begin
      if (in_rst)     key_half <= 1'b0;
      else if (wr_en) key_half <= (wr_data == KEY_FIRST);

      if (in_rst)       wake_hold <= 1'b0;
      else if (pd_wake) wake_hold <= 1'b1;
      else if (irq_n)   wake_hold <= 1'b0;

      if (hit)         pls <= PW'(PULSE_LEN);
      else if (in_rst) pls <= pls - 1'b1;

      if (hit || in_rst) armed <= 1'b0;
      else if (key_done) armed <= 1'b1;

      if (hit || in_rst || key_done) cnt <= '0;
      else if (advance)              cnt <= cnt + 1'b1;
    end
  end

  assign wdt_reset_req = in_rst;
  assign rst_pin_drive = in_rst && !rstout_dis;

endmodule

// File: rtl/wdog_unlock_chk.sv
module wdog_unlock_chk #(
  parameter int         PULSE_LEN  = 98,
  parameter logic [7:0] KEY_FIRST  = 8'h1E,
  parameter logic [7:0] KEY_SECOND = 8'hE1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_en,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       pdown,
  input logic       rstout_dis,
  input logic       wdt_reset_req,
  input logic       rst_pin_drive
);

  logic [15:0] plen;
  logic        sh_half, sh_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plen     <= '0;
      sh_half  <= 1'b0;
      sh_armed <= 1'b0;
    end else begin
      plen <= wdt_reset_req ? plen + 1'b1 : '0;
      if (wdt_reset_req) sh_half <= 1'b0;
      else if (wr_en)    sh_half <= (wr_data == KEY_FIRST);
      if (wdt_reset_req) sh_armed <= 1'b0;
      else if (wr_en && sh_half && wr_data == KEY_SECOND) sh_armed <= 1'b1;
    end
  end

  assert_req_needs_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset_req) |-> sh_armed);

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_reset_req) |-> plen == 16'(PULSE_LEN));

  assert_pin_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_reset_req && rstout_dis) |-> !rst_pin_drive);

  assert_pin_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_reset_req && !rstout_dis) |-> rst_pin_drive);

  assert_no_fire_pdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pdown |=> !$rose(wdt_reset_req));

  assert_fire_on_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> !$rose(wdt_reset_req));

endmodule

bind wdog_unlock wdog_unlock_chk #(
  .PULSE_LEN(PULSE_LEN), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_en(wr_en), .wr_data(wr_data),
  .pdown(pdown), .rstout_dis(rstout_dis),
  .wdt_reset_req(wdt_reset_req), .rst_pin_drive(rst_pin_drive)
);

// File: tb/wdog_unlock_tb.sv
`timescale 1ns/1ps
module wdog_unlock_tb;
  localparam int LAST = 16383;
  localparam int PLEN = 98;

  logic clk = 0, rst_n = 0, cyc_en = 1, wr_en = 0, idle = 0, halt_in_idle = 0;
  logic pdown = 0, pd_wake = 0, irq_n = 1, rstout_dis = 0;
  logic [7:0] wr_data = 0;
  logic wdt_reset_req, rst_pin_drive;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wdog_unlock u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_en(wr_en), .wr_data(wr_data),
    .idle(idle), .halt_in_idle(halt_in_idle), .pdown(pdown), .pd_wake(pd_wake),
    .irq_n(irq_n), .rstout_dis(rstout_dis),
    .wdt_reset_req(wdt_reset_req), .rst_pin_drive(rst_pin_drive)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; cyc_en = 1; idle = 0; halt_in_idle = 0;
    pdown = 0; pd_wake = 0; irq_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic kick();
    wr(8'h1E);
    wr(8'hE1);
  endtask

  task automatic quiet(input int len, output int rises);
    rises = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (wdt_reset_req || rst_pin_drive) rises++;
    end
  endtask

  task automatic run(input int mode, output int n, output int e);
    n = 0; e = 0;
    while (n < 40000) begin
      wr_en = 0; pd_wake = 0; cyc_en = 1;
      case (mode)
        1: begin
          halt_in_idle = (n >= 150);
          idle  = (n >= 100 && n < 150) || (n >= 200 && n < 240);
          pdown = (n >= 300 && n < 310);
          pd_wake = (n == 310);
          irq_n = !(n >= 310 && n < 330);
        end
        2: cyc_en = (n % 4 != 3);
        3: begin
          if (n == 50)  begin wr_en = 1; wr_data = 8'h1E; end
          if (n == 51)  begin wr_en = 1; wr_data = 8'h55; end
          if (n == 52)  begin wr_en = 1; wr_data = 8'hE1; end
          if (n == 100) begin wr_en = 1; wr_data = 8'hE1; end
          if (n == 150) begin wr_en = 1; wr_data = 8'h1E; end
          if (n == 151) begin wr_en = 1; wr_data = 8'h00; end
          if (n == 152) begin wr_en = 1; wr_data = 8'hE1; end
        end
        4: begin
          if (n == 1000) begin wr_en = 1; wr_data = 8'h1E; end
          if (n == 1001) begin wr_en = 1; wr_data = 8'h1E; end
          if (n == 1002) begin wr_en = 1; wr_data = 8'hE1; end
        end
        default: ;
      endcase
      if (cyc_en) e++;
      @(negedge clk);
      n++;
      if (wdt_reset_req) break;
    end
    wr_en = 0; pd_wake = 0; cyc_en = 1; idle = 0; pdown = 0; irq_n = 1;
    halt_in_idle = 0;
  endtask

  task automatic width(output int w, output int pw);
    w = 0; pw = 0;
    while (wdt_reset_req && w < 300) begin
      if (rst_pin_drive) pw++;
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n, e, w, pw, r;
    do_reset();
    chk(!wdt_reset_req && !rst_pin_drive, "R1 reset state", wdt_reset_req, 0);
    wr(8'hE1); wr(8'h1E);
    quiet(17000, r);
    chk(r == 0, "R1/R4 no request without key", r, 0);

    kick(); run(0, n, e);
    chk(n == LAST, "R2 distance to request", n, LAST);
    width(w, pw);
    chk(w == PLEN, "R6 request length", w, PLEN);
    chk(pw == PLEN, "R7 pin driven whole request", pw, PLEN);

    do_reset(); kick(); run(1, n, e);
    chk(n == LAST + 70, "R8/R9 idle, power-down and wake hold", n, LAST + 70);
    width(w, pw);

    do_reset(); kick(); run(2, n, e);
    chk(e == LAST, "R5 machine cycles counted", e, LAST);
    chk(n > LAST, "R5 clocks exceed cycles", n, LAST + 5461);
    width(w, pw);

    do_reset(); kick(); run(3, n, e);
    chk(n == LAST, "R4 broken keys ignored", n, LAST);
    width(w, pw);

    do_reset(); kick(); run(4, n, e);
    chk(n == 1003 + LAST, "R3 restart key", n, 1003 + LAST);
    width(w, pw);

    do_reset(); rstout_dis = 1; kick(); run(0, n, e);
    chk(n == LAST, "R7 distance with pin disabled", n, LAST);
    width(w, pw);
    chk(w == PLEN, "R7 internal request still pulses", w, PLEN);
    chk(pw == 0, "R7 pin never driven", pw, 0);
    quiet(17000, r);
    chk(r == 0, "R10 off after request", r, 0);
    rstout_dis = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule